// File: doc/BRIEF.md
# Load/Store Byte Alignment Datapath

This block sits between a 64-bit data cache port and the integer register file. It handles one memory access per clock. For a load, it takes the eight bytes read from the cache and picks out the one, two, four or eight bytes the access names, starting at any byte offset. It packs them into the low end of the result, orders them for the selected byte order, and fills the upper bytes with zeros or with copies of the sign bit.

For a store, it works the other way round. It takes the low bytes of the register value and places them in the lanes the access covers. It also produces a write-enable bit for each of those lanes.

Any access whose bytes all fall inside the one aligned 8-byte slice is finished in a single cycle, whatever its alignment, in either byte order. An access that would run past the last lane is not split. It is reported on a flag instead, and nothing is written. Every result is registered and appears one clock after the request.

Top module: `ls_align_top`

## Requirements
- R1: The size code selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Byte address offset k of the slice is carried on `rdData[8k+7:8k]` and `wrData[8k+7:8k]`, and load results are right-justified in `ldData`.
- R2: With `littleEnd`=0, the byte at the lowest address of a load becomes the most significant byte of the loaded value.
- R3: With `littleEnd`=1, the byte at the lowest address of a load becomes the least significant byte of the loaded value.
- R4: An unsigned load fills the bits above the loaded value with zeros. A signed load of 1, 2 or 4 bytes fills them with the top bit of the loaded value. A signed 8-byte load gives the same result as an unsigned one.
- R5: A store sets `byteEn` bit k exactly for the lanes from `byteOff` to `byteOff`+size-1. It places the low bytes of `stData` in those lanes, in the selected byte order (the lowest lane gets the most significant byte when `littleEnd`=0, and the least significant byte when `littleEnd`=1). All other lanes of `wrData` are zero.
- R6: When `byteOff` plus the access size exceeds 8, `crossFlag` is 1 and `byteEn`, `wrData` and the load result are all zero.
- R7: An access at any offset that fits in the slice completes in one cycle, and requests on consecutive cycles each produce their own result on consecutive cycles.
- R8: All outputs are registered. They reflect a request exactly one clock after `reqValid` is sampled high, and `resValid` is high in that cycle only if a request was accepted on the previous edge.
- R9: Synchronous active-high `rst` clears every output. After a cycle without a request, `resValid`, `byteEn` and `crossFlag` are 0, and `ldData` keeps its last value.
- R10: A load never raises `byteEn`, and it drives `wrData` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Access request strobe |
| isStore | input | 1 | 1 = store, 0 = load |
| byteOff | input | 3 | Byte offset of the lowest address within the slice |
| sizeCode | input | 2 | Access width code (see R1) |
| signedLd | input | 1 | Sign-extend the load result |
| littleEnd | input | 1 | 1 = little-endian byte order, 0 = big-endian |
| rdData | input | 64 | Slice read from the data cache |
| stData | input | 64 | Register value to store, right-justified |
| ldData | output | 64 | Aligned and extended load result |
| wrData | output | 64 | Store data placed in its lanes |
| byteEn | output | 8 | Per-lane write enables |
| crossFlag | output | 1 | Access would leave the slice |
| resValid | output | 1 | Result valid |

## Verification
The bench builds the block with its default of eight lanes. At that width, every combination of the eight offsets, four sizes, both byte orders, load or store, and the signed flag can be swept exhaustively. The sweep covers every case that fits, and every case that runs past lane 7: a doubleword at any nonzero offset, a word at offsets 5 to 7, and a halfword at offset 7. Hand-computed literal values pin down the byte order and the sign fill, so they are not checked only against the bench's own model.

// File: rtl/ls_align_pkg.sv
package ls_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } accSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic loadOp;
    logic storeOp;
    logic crossed;
    logic bigEnd;
    logic signExt;
  } alignStrobe_t;

endpackage

// File: rtl/ls_align_ctrl.sv
module ls_align_ctrl
  import ls_align_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  input  logic                 isStore,
  input  logic [OFF_W-1:0]     byteOff,
  input  logic [1:0]           sizeCode,
  input  logic                 signedLd,
  input  logic                 littleEnd,
  output alignStrobe_t         strb,
  output logic [LANES-1:0]     laneMask,
  output logic [CNT_W-1:0]     byteCnt
);

  logic crossRaw;
  int   endPos;

  always_comb begin
    byteCnt  = CNT_W'(1) << sizeCode;
    endPos   = int'(byteOff) + int'(byteCnt);
    crossRaw = endPos > LANES;
    for (int k = 0; k < LANES; k++) begin
      laneMask[k] = !crossRaw && (k >= int'(byteOff)) && (k < endPos);
    end
  end

  always_comb begin
    strb.capture = reqValid;
    strb.loadOp  = reqValid && !isStore;
    strb.storeOp = reqValid && isStore;
    strb.crossed = reqValid && crossRaw;
    strb.bigEnd  = !littleEnd;
    strb.signExt = signedLd && (accSize_e'(sizeCode) != SZ_DBL);
  end

  // R1: a contained access covers exactly its size in lanes
  p_mask_size_r1: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !crossRaw) |-> ($countones(laneMask) == int'(byteCnt)));

  // R6: an overrun access selects no lane
  p_cross_nomask_r6: assert property (@(posedge clk) disable iff (rst)
    strb.crossed |-> (laneMask == '0));

endmodule

// File: rtl/ls_align_dp.sv
module ls_align_dp
  import ls_align_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1,
  localparam int LINE_W = 8 * LANES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  alignStrobe_t         strb,
  input  logic [LANES-1:0]     laneMask,
  input  logic [OFF_W-1:0]     byteOff,
  input  logic [CNT_W-1:0]     byteCnt,
  input  logic [LINE_W-1:0]    rdData,
  input  logic [LINE_W-1:0]    stData,
  output logic [LINE_W-1:0]    ldData,
  output logic [LINE_W-1:0]    wrData,
  output logic [LANES-1:0]     byteEn,
  output logic                 crossFlag,
  output logic                 resValid
);

  logic [LINE_W-1:0] loadNext;
  logic [LINE_W-1:0] storeNext;
  logic              signBit;
  int                srcLd;
  int                srcSt;

  // Load extraction, ordering and extension
  always_comb begin
    loadNext = '0;
    signBit  = 1'b0;
    srcLd    = 0;
    for (int j = 0; j < LANES; j++) begin
      if (j < int'(byteCnt)) begin
        srcLd = strb.bigEnd ? int'(byteOff) + int'(byteCnt) - 1 - j
                            : int'(byteOff) + j;
        if (srcLd < LANES) loadNext[8*j +: 8] = rdData[8*srcLd +: 8];
        if (j == int'(byteCnt) - 1) signBit = loadNext[8*j + 7];
      end
    end
    for (int j = 0; j < LANES; j++) begin
      if (j >= int'(byteCnt) && strb.signExt && signBit) loadNext[8*j +: 8] = 8'hFF;
    end
  end

  // Store lane placement
  always_comb begin
    storeNext = '0;
    srcSt     = 0;
    for (int k = 0; k < LANES; k++) begin
      if (laneMask[k]) begin
        srcSt = strb.bigEnd ? int'(byteCnt) - 1 - (k - int'(byteOff))
                            : k - int'(byteOff);
        if (srcSt >= 0 && srcSt < LANES) storeNext[8*k +: 8] = stData[8*srcSt +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ldData    <= '0;
      wrData    <= '0;
      byteEn    <= '0;
      crossFlag <= 1'b0;
      resValid  <= 1'b0;
    end else begin
      resValid  <= strb.capture;
      crossFlag <= strb.crossed;
      if (strb.storeOp && !strb.crossed) begin
        byteEn <= laneMask;
        wrData <= storeNext;
      end else begin
        byteEn <= '0;
        wrData <= '0;
      end
      if (strb.loadOp) ldData <= strb.crossed ? '0 : loadNext;
    end
  end

  // R8: result valid one cycle after each request, never without one
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
    strb.capture |=> resValid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> !resValid);

  // R6: overrun writes nothing
  p_cross_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    crossFlag |-> (byteEn == '0 && wrData == '0));

  // R5: enabled lane count equals the store size
  p_store_count_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(strb.storeOp) && !crossFlag) |-> ($countones(byteEn) == int'($past(byteCnt))));

  // R10: loads never enable a lane
  p_load_noen_r10: assert property (@(posedge clk) disable iff (rst)
    $past(strb.loadOp) |-> (byteEn == '0));

  // R9: load result held when no load was taken
  p_ld_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strb.loadOp |=> $stable(ldData));

endmodule

// File: rtl/ls_align_top.sv
module ls_align_top
  import ls_align_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1,
  localparam int LINE_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              isStore,
  input  logic [OFF_W-1:0]  byteOff,
  input  logic [1:0]        sizeCode,
  input  logic              signedLd,
  input  logic              littleEnd,
  input  logic [LINE_W-1:0] rdData,
  input  logic [LINE_W-1:0] stData,
  output logic [LINE_W-1:0] ldData,
  output logic [LINE_W-1:0] wrData,
  output logic [LANES-1:0]  byteEn,
  output logic              crossFlag,
  output logic              resValid
);

  alignStrobe_t     strb;
  logic [LANES-1:0] laneMask;
  logic [CNT_W-1:0] byteCnt;

  ls_align_ctrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .isStore  (isStore),
    .byteOff  (byteOff),
    .sizeCode (sizeCode),
    .signedLd (signedLd),
    .littleEnd(littleEnd),
    .strb     (strb),
    .laneMask (laneMask),
    .byteCnt  (byteCnt)
  );

  ls_align_dp #(.LANES(LANES)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .laneMask (laneMask),
    .byteOff  (byteOff),
    .byteCnt  (byteCnt),
    .rdData   (rdData),
    .stData   (stData),
    .ldData   (ldData),
    .wrData   (wrData),
    .byteEn   (byteEn),
    .crossFlag(crossFlag),
    .resValid (resValid)
  );

endmodule

// File: tb/sim_ls_align_top.sv
`timescale 1ns/1ps
module sim_ls_align_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        isStore = 1'b0;
  logic [2:0]  byteOff = '0;
  logic [1:0]  sizeCode = '0;
  logic        signedLd = 1'b0;
  logic        littleEnd = 1'b0;
  logic [63:0] rdData = '0;
  logic [63:0] stData = '0;
  logic [63:0] ldData;
  logic [63:0] wrData;
  logic [7:0]  byteEn;
  logic        crossFlag;
  logic        resValid;

  int errors = 0;
  int checks = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #2 clk = ~clk;

  ls_align_top u0 (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic bit overruns(input int off, input int sz);
    return (off + (1 << sz)) > 8;
  endfunction

  // Expected load value from the requirements (address order assembly)
  function automatic logic [63:0] expLoad(input logic [63:0] rd, input int off, input int sz,
                                          input bit sgn, input bit le);
    logic [63:0] v = '0;
    int n = 1 << sz;
    if (overruns(off, sz)) return '0;
    for (int i = 0; i < n; i++) begin
      if (le) v = v | (64'(rd[8*(off+i) +: 8]) << (8*i));
      else    v = (v << 8) | 64'(rd[8*(off+i) +: 8]);
    end
    if (sgn && sz < 3 && v[8*n-1]) v = v | ~((64'd1 << (8*n)) - 64'd1);
    return v;
  endfunction

  function automatic logic [63:0] expStore(input logic [63:0] sd, input int off, input int sz, input bit le);
    logic [63:0] w = '0;
    int n = 1 << sz;
    if (overruns(off, sz)) return '0;
    for (int i = 0; i < n; i++) begin
      w[8*(off+i) +: 8] = le ? sd[8*i +: 8] : sd[8*(n-1-i) +: 8];
    end
    return w;
  endfunction

  function automatic logic [7:0] expEn(input int off, input int sz);
    logic [7:0] e = '0;
    if (overruns(off, sz)) return '0;
    for (int i = 0; i < (1 << sz); i++) e[off+i] = 1'b1;
    return e;
  endfunction

  task automatic drive(input bit st, input int off, input int sz, input bit sgn, input bit le,
                       input logic [63:0] rd, input logic [63:0] sd);
    reqValid  = 1'b1;
    isStore   = st;
    byteOff   = 3'(off);
    sizeCode  = 2'(sz);
    signedLd  = sgn;
    littleEnd = le;
    rdData    = rd;
    stData    = sd;
  endtask

  task automatic checkResult(input string req, input bit st, input int off, input int sz, input bit sgn,
                             input bit le, input logic [63:0] rd, input logic [63:0] sd);
    chk(req, "resValid", 64'(resValid), 64'd1);
    chk("R6", "crossFlag", 64'(crossFlag), 64'(overruns(off, sz)));
    if (st) begin
      chk(req, "byteEn", 64'(byteEn), 64'(expEn(off, sz)));
      chk(req, "wrData", wrData, expStore(sd, off, sz, le));
    end else begin
      chk("R10", "byteEn on load", 64'(byteEn), 64'd0);
      chk("R10", "wrData on load", wrData, 64'd0);
      chk(req, "ldData", ldData, expLoad(rd, off, sz, sgn, le));
    end
  endtask

  task automatic access(input string req, input bit st, input int off, input int sz, input bit sgn,
                        input bit le, input logic [63:0] rd, input logic [63:0] sd);
    @(negedge clk);
    drive(st, off, sz, sgn, le, rd, sd);
    @(negedge clk);
    reqValid = 1'b0;
    checkResult(req, st, off, sz, sgn, le, rd, sd);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "resValid in reset", 64'(resValid), 64'd0);
    chk("R9", "byteEn in reset", 64'(byteEn), 64'd0);
    chk("R9", "ldData in reset", ldData, 64'd0);
    chk("R9", "crossFlag in reset", 64'(crossFlag), 64'd0);
    rst = 1'b0;
  endtask

  task automatic testLoadOrder();
    logic [63:0] rd = 64'h8877665544332211;
    access("R2", 1'b0, 1, 2, 1'b0, 1'b0, rd, '0);
    chk("R2", "literal BE word off1", ldData, 64'h0000000022334455);
    access("R3", 1'b0, 1, 2, 1'b0, 1'b1, rd, '0);
    chk("R3", "literal LE word off1", ldData, 64'h0000000055443322);
    access("R1", 1'b0, 3, 0, 1'b0, 1'b0, rd, '0);
    chk("R1", "literal byte off3", ldData, 64'h0000000000000044);
    access("R1", 1'b0, 0, 3, 1'b0, 1'b1, rd, '0);
    chk("R1", "literal LE dword", ldData, 64'h8877665544332211);
  endtask

  task automatic testSign();
    logic [63:0] rd = 64'h8877665544332211;
    access("R4", 1'b0, 7, 0, 1'b1, 1'b0, rd, '0);
    chk("R4", "signed byte 0x88", ldData, 64'hFFFFFFFFFFFFFF88);
    access("R4", 1'b0, 6, 1, 1'b0, 1'b0, rd, '0);
    chk("R4", "unsigned half", ldData, 64'h0000000000007788);
    access("R4", 1'b0, 4, 2, 1'b1, 1'b1, rd, '0);
    chk("R4", "signed LE word", ldData, 64'hFFFFFFFF88776655);
    access("R4", 1'b0, 0, 3, 1'b1, 1'b0, rd, '0);
    chk("R4", "signed dword as unsigned", ldData, 64'h1122334455667788);
    access("R4", 1'b0, 0, 0, 1'b1, 1'b0, rd, '0);
    chk("R4", "signed positive byte", ldData, 64'h0000000000000011);
  endtask

  task automatic testStore();
    access("R5", 1'b1, 3, 1, 1'b0, 1'b0, '0, 64'h000000000000ABCD);
    chk("R5", "BE half lanes", wrData, 64'h000000CDAB000000);
    chk("R5", "BE half enables", 64'(byteEn), 64'h18);
    access("R5", 1'b1, 3, 1, 1'b0, 1'b1, '0, 64'hFFFFFFFFFFFFABCD);
    chk("R5", "LE half lanes", wrData, 64'h000000ABCD000000);
  endtask

  task automatic testCross();
    access("R6", 1'b1, 6, 2, 1'b0, 1'b0, '0, 64'h12345678);
    chk("R6", "overrun store enables", 64'(byteEn), 64'd0);
    access("R6", 1'b0, 7, 1, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFF, '0);
    chk("R6", "overrun load data", ldData, 64'd0);
  endtask

  task automatic testBackToBack();
    logic [63:0] rdA = nextRand();
    logic [63:0] sdB = nextRand();
    logic [63:0] held;
    @(negedge clk);
    drive(1'b0, 5, 1, 1'b1, 1'b1, rdA, '0);
    @(negedge clk);
    checkResult("R7", 1'b0, 5, 1, 1'b1, 1'b1, rdA, '0);
    drive(1'b1, 1, 2, 1'b0, 1'b0, '0, sdB);
    @(negedge clk);
    checkResult("R7", 1'b1, 1, 2, 1'b0, 1'b0, '0, sdB);
    chk("R8", "ldData untouched by store", ldData, expLoad(rdA, 5, 1, 1'b1, 1'b1));
    held = ldData;
    reqValid = 1'b0;
    @(negedge clk);
    chk("R8", "resValid after idle", 64'(resValid), 64'd0);
    chk("R9", "byteEn after idle", 64'(byteEn), 64'd0);
    chk("R9", "crossFlag after idle", 64'(crossFlag), 64'd0);
    chk("R9", "ldData held", ldData, held);
  endtask

  task automatic testSweep();
    for (int off = 0; off < 8; off++)
      for (int sz = 0; sz < 4; sz++)
        for (int le = 0; le < 2; le++)
          for (int st = 0; st < 2; st++)
            for (int sg = 0; sg < 2; sg++)
              access(overruns(off, sz) ? "R6" : "R7", st[0], off, sz, sg[0], le[0], nextRand(), nextRand());
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testLoadOrder();
    testSign();
    testStore();
    testCross();
    testBackToBack();
    testSweep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule